// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory can accept normal traffic. It holds the clock enable low at first and then raises it partway through a long stabilization wait. During that wait only deselect or no-operation codes go out. When the wait ends, the block issues a precharge to every bank, a configurable number of auto-refresh commands, and finally a mode-register load that carries burst length, CAS latency and write-burst mode. It then raises a done flag. The controller behind it takes over the bus once done is high.

Every wait is set in nanoseconds and converted to clock cycles when the design is elaborated. The conversion is a ceiling division by the clock period, with a minimum of one cycle. A single down-counter times each step and is reloaded whenever the step changes. A second small counter tracks how many refresh commands are still to be issued. The sequence runs exactly once after each reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, the clock enable is low, chip select is high, bank and address outputs are zero, and done is low.
- R2: After reset is released, the clock enable rises once CKE_LOW_CYC clocks have passed, where CKE_LOW_CYC = ceil(T_CKE_LOW_NS*1000/CLK_PERIOD_PS). It then stays high. While it is low, the command is deselect ({cs_n,ras_n,cas_n,we_n}=1111). Between commands the code is no-operation (0111).
- R3: The first command is a precharge of all banks (0111 becomes 0010, with address bit 10 high and every other address and bank bit low). It is sampled on the STABLE_CYC-th clock edge after reset is released.
- R4: After the precharge come exactly RP_CYC no-operation cycles, then the first auto-refresh (0001).
- R5: Each auto-refresh is followed by exactly RFC_CYC no-operation cycles. Exactly REFRESH_LOOPS refreshes are issued, and REFRESH_LOOPS is at least two.
- R6: After the last refresh wait, a mode-register load (0000) goes out with both bank bits at zero. The address carries the burst code in bits 2:0, the CAS latency in bits 6:4 and the write-single flag in bit 9. All other address bits are zero.
- R7: After the mode-register load come exactly MRD_CYC no-operation cycles, then done goes high. Each wait in cycles is ceil(time_ns*1000/CLK_PERIOD_PS), with a minimum of one.
- R8: Once high, done stays high until reset. The clock enable stays high, and only no-operation is issued.
- R9: A reset applied partway through the sequence returns the outputs to the R1 state at once. After release, the whole sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus (A10 selects all banks on precharge; mode word on load) |
| init_done | output | 1 | High once the memory is ready for traffic |

## Verification
The bench sets non-integer waits so that the ceiling rounding shows up in the cycle counts. A design that truncates would issue the refresh or the mode load one cycle early. It sets three refresh loops, and a loop counter that is off by one then shows up as a missing or extra refresh before the mode load. It checks the exact cycle at which the clock enable rises and the deselect/no-operation coding on either side of that rise. It also resets the block during the first refresh wait. A sequencer that keeps its loop or timer state across reset would then resume partway through instead of starting again with the long wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [2:0] {
      ST_WAIT, ST_PRE, ST_TRP, ST_REF, ST_TRFC, ST_LMR, ST_TMRD, ST_DONE
   } step_e;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_INH = 4'b1111;
   localparam logic [3:0] CMD_NOP = 4'b0111;
   localparam logic [3:0] CMD_PRE = 4'b0010;
   localparam logic [3:0] CMD_REF = 4'b0001;
   localparam logic [3:0] CMD_LMR = 4'b0000;

   function automatic int ns_to_cyc(input int t_ns, input int period_ps);
      int c;
      c = (t_ns * 1000 + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          count <= RST_VAL;
      else if (load)       count <= load_val;
      else if (count != 0) count <= count - 1'b1;
   end

   assign zero = (count == '0);
endmodule

// File: rtl/sdram_init_cmd_dec.sv
module sdram_init_cmd_dec
   import sdram_init_pkg::*;
#(
   parameter int                ADDR_W    = 13,
   parameter int                BA_W      = 2,
   parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
   input  step_e             step,
   input  logic              cke,
   output logic [3:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

   always_comb begin
      ba   = '0;
      addr = '0;
      unique case (step)
         ST_PRE: begin
            cmd  = CMD_PRE;
            addr = ALL_BANKS;
         end
         ST_REF:  cmd = CMD_REF;
         ST_LMR: begin
            cmd  = CMD_LMR;
            addr = MODE_WORD;
         end
         ST_WAIT: cmd = cke ? CMD_NOP : CMD_INH;
         default: cmd = CMD_NOP;
      endcase
   end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int         CLK_PERIOD_PS = 10000,
   parameter int         T_STABLE_NS   = 100000,
   parameter int         T_CKE_LOW_NS  = 50000,
   parameter int         T_RP_NS       = 20,
   parameter int         T_RFC_NS      = 70,
   parameter int         T_MRD_NS      = 20,
   parameter int         REFRESH_LOOPS = 2,
   parameter logic [2:0] BURST_CODE    = 3'b011,
   parameter logic [2:0] CAS_LAT       = 3'd3,
   parameter bit         WRITE_SINGLE  = 1'b0,
   parameter int         ADDR_W        = 13,
   parameter int         BA_W          = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BA_W-1:0]   mem_ba,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              init_done
);
   localparam int STABLE_CYC  = ns_to_cyc(T_STABLE_NS, CLK_PERIOD_PS);
   localparam int CKE_LOW_CYC = ns_to_cyc(T_CKE_LOW_NS, CLK_PERIOD_PS);
   localparam int RP_CYC      = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
   localparam int RFC_CYC     = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS);
   localparam int MRD_CYC     = ns_to_cyc(T_MRD_NS, CLK_PERIOD_PS);
   localparam int MAX_CYC     = max2(max2(STABLE_CYC, RP_CYC), max2(RFC_CYC, MRD_CYC));
   localparam int CNT_W       = $clog2(MAX_CYC + 1);
   localparam int LOOP_W      = $clog2(REFRESH_LOOPS + 1);
   localparam int CKE_BELOW   = STABLE_CYC - CKE_LOW_CYC;
   localparam logic [ADDR_W-1:0] MODE_WORD =
      ADDR_W'({WRITE_SINGLE, 2'b00, CAS_LAT, 1'b0, BURST_CODE});

   generate
      if (REFRESH_LOOPS < 2) begin : g_chk_loops
         $error("REFRESH_LOOPS must be at least 2");
      end
      if (ADDR_W < 11) begin : g_chk_addr
         $error("ADDR_W must reach the all-bank bit 10");
      end
      if (BA_W < 1) begin : g_chk_ba
         $error("BA_W must be at least 1");
      end
      if (T_STABLE_NS < 100000) begin : g_chk_stable
         $error("stabilization wait must be at least 100 us");
      end
      if (CKE_LOW_CYC >= STABLE_CYC) begin : g_chk_cke
         $error("clock enable must rise inside the stabilization wait");
      end
   endgenerate

   step_e             step_q, step_nxt;
   logic              tmr_zero, advance;
   logic [CNT_W-1:0]  tmr_count, tmr_load_val;
   logic [LOOP_W-1:0] loops_left;
   logic              last_loop;
   int                dur;

   assign last_loop = (loops_left == '0);
   assign advance   = (step_q != ST_DONE) && tmr_zero;

   always_comb begin
      unique case (step_q)
         ST_WAIT: step_nxt = ST_PRE;
         ST_PRE:  step_nxt = ST_TRP;
         ST_TRP:  step_nxt = ST_REF;
         ST_REF:  step_nxt = ST_TRFC;
         ST_TRFC: step_nxt = last_loop ? ST_LMR : ST_REF;
         ST_LMR:  step_nxt = ST_TMRD;
         default: step_nxt = ST_DONE;
      endcase
   end

   always_comb begin
      unique case (step_nxt)
         ST_TRP:  dur = RP_CYC;
         ST_TRFC: dur = RFC_CYC;
         ST_TMRD: dur = MRD_CYC;
         default: dur = 1;
      endcase
      tmr_load_val = CNT_W'(dur - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q     <= ST_WAIT;
         loops_left <= LOOP_W'(REFRESH_LOOPS - 1);
      end else if (advance) begin
         step_q <= step_nxt;
         if (step_q == ST_TRFC && !last_loop)
            loops_left <= loops_left - 1'b1;
      end
   end

   sdram_init_timer #(
      .W       (CNT_W),
      .RST_VAL (CNT_W'(STABLE_CYC - 1))
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (advance),
      .load_val (tmr_load_val),
      .count    (tmr_count),
      .zero     (tmr_zero)
   );

   assign mem_cke = (step_q != ST_WAIT) || (tmr_count < CNT_W'(CKE_BELOW));

   logic [3:0] cmd;

   sdram_init_cmd_dec #(
      .ADDR_W    (ADDR_W),
      .BA_W      (BA_W),
      .MODE_WORD (MODE_WORD)
   ) i_dec (
      .step (step_q),
      .cke  (mem_cke),
      .cmd  (cmd),
      .ba   (mem_ba),
      .addr (mem_addr)
   );

   assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
   assign init_done = (step_q == ST_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
   import sdram_init_pkg::*;
#(
   parameter int RP_CYC  = 2,
   parameter int RFC_CYC = 7,
   parameter int MRD_CYC = 2,
   parameter int LOOPS   = 2,
   parameter int ADDR_W  = 13,
   parameter int BA_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_cke,
   input logic              mem_cs_n,
   input logic              mem_ras_n,
   input logic              mem_cas_n,
   input logic              mem_we_n,
   input logic [BA_W-1:0]   mem_ba,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              init_done
);
   localparam int IW = $clog2(max2(max2(RP_CYC, RFC_CYC), MRD_CYC) + 2) + 1;
   localparam int LW = $clog2(LOOPS + 2) + 1;

   logic [3:0]    cmd;
   logic          is_cmd;
   logic [IW-1:0] idle_run;
   logic [LW-1:0] ref_seen;

   assign cmd    = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
   assign is_cmd = (cmd != CMD_NOP) && !mem_cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_run <= '0;
         ref_seen <= '0;
      end else begin
         if (is_cmd)            idle_run <= '0;
         else if (~&idle_run)   idle_run <= idle_run + 1'b1;
         if (cmd == CMD_REF && ~&ref_seen) ref_seen <= ref_seen + 1'b1;
      end
   end

   // R2
   cke_low_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cke |-> mem_cs_n);
   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cke |=> mem_cke);
   // R3
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_PRE |-> mem_addr[10]);
   // R4
   ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_REF |-> idle_run >= IW'(max2(1, (RP_CYC < RFC_CYC) ? RP_CYC : RFC_CYC)));
   // R5
   lmr_loops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_LMR |-> ref_seen == LW'(LOOPS));
   // R6
   lmr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_LMR |-> mem_ba == '0);
   // R7
   done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> idle_run >= IW'(MRD_CYC));
   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd == CMD_NOP) && mem_cke);
endmodule

bind sdram_init_seq sdram_init_chk #(
   .RP_CYC  (RP_CYC),
   .RFC_CYC (RFC_CYC),
   .MRD_CYC (MRD_CYC),
   .LOOPS   (REFRESH_LOOPS),
   .ADDR_W  (ADDR_W),
   .BA_W    (BA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_cke   (mem_cke),
   .mem_cs_n  (mem_cs_n),
   .mem_ras_n (mem_ras_n),
   .mem_cas_n (mem_cas_n),
   .mem_we_n  (mem_we_n),
   .mem_ba    (mem_ba),
   .mem_addr  (mem_addr),
   .init_done (init_done)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
   localparam int PERIOD_PS = 10000;
   localparam int STABLE_NS = 100000;
   localparam int CKEL_NS   = 40000;
   localparam int RP_NS     = 15;
   localparam int RFC_NS    = 65;
   localparam int MRD_NS    = 25;
   localparam int LOOPS     = 3;
   localparam logic [2:0] BL = 3'b010;
   localparam logic [2:0] CL = 3'd2;
   localparam bit         WB = 1'b1;
   localparam int AW = 13;
   localparam int BW = 2;

   localparam logic [3:0] C_INH = 4'b1111, C_NOP = 4'b0111,
                          C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

   function automatic int cyc(input int ns);
      int c;
      c = (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int S   = cyc(STABLE_NS);
   localparam int CKL = cyc(CKEL_NS);
   localparam int RP  = cyc(RP_NS);
   localparam int RFC = cyc(RFC_NS);
   localparam int MRD = cyc(MRD_NS);

   logic clk = 1'b0, rst_n = 1'b0;
   logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
   logic [BW-1:0] mem_ba;
   logic [AW-1:0] mem_addr;

   always #5 clk = ~clk;

   sdram_init_seq #(
      .CLK_PERIOD_PS (PERIOD_PS), .T_STABLE_NS (STABLE_NS), .T_CKE_LOW_NS (CKEL_NS),
      .T_RP_NS (RP_NS), .T_RFC_NS (RFC_NS), .T_MRD_NS (MRD_NS),
      .REFRESH_LOOPS (LOOPS), .BURST_CODE (BL), .CAS_LAT (CL), .WRITE_SINGLE (WB),
      .ADDR_W (AW), .BA_W (BW)
   ) i_sdram_init_seq (
      .clk (clk), .rst_n (rst_n), .mem_cke (mem_cke), .mem_cs_n (mem_cs_n),
      .mem_ras_n (mem_ras_n), .mem_cas_n (mem_cas_n), .mem_we_n (mem_we_n),
      .mem_ba (mem_ba), .mem_addr (mem_addr), .init_done (init_done)
   );

   typedef struct {
      logic [3:0]    cmd;
      int            k;
      logic [AW-1:0] addr;
      string         req;
   } exp_t;

   exp_t q[$];
   int   total = 0, bad = 0, k = 0, done_k = 0;
   bit   ended = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // driver: expected command stream
   task automatic push_seq();
      exp_t e;
      int   t;
      q.delete();
      e.cmd = C_PRE; e.k = S; e.addr = AW'(1) << 10; e.req = "R3"; q.push_back(e);
      t = S + RP + 1;
      for (int i = 0; i < LOOPS; i++) begin
         e.cmd = C_REF; e.k = t; e.addr = '0; e.req = (i == 0) ? "R4" : "R5";
         q.push_back(e);
         t += RFC + 1;
      end
      e.cmd = C_LMR; e.k = t; e.req = "R6";
      e.addr = AW'((int'(WB) << 9) | (int'(CL) << 4) | int'(BL));
      q.push_back(e);
      done_k = t + MRD + 1;
   endtask

   task automatic reset_state(input string req);
      chk(mem_cke == 1'b0, req, "cke in reset", mem_cke, 0);
      chk(mem_cs_n == 1'b1, req, "cs_n in reset", mem_cs_n, 1);
      chk(init_done == 1'b0, req, "done in reset", init_done, 0);
      chk(mem_addr == '0 && mem_ba == '0, req, "addr/ba in reset",
          {mem_ba, mem_addr}, 0);
   endtask

   task automatic wait_k(input int target);
      do begin @(negedge clk); #1; end while (k < target);
   endtask

   // monitor: compares outputs against the expected stream
   always @(negedge clk) begin
      if (!rst_n) k = 0;
      else begin
         logic [3:0] c;
         exp_t e;
         k++;
         c = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
         chk(mem_cke == (k >= CKL), "R2", "cke level", mem_cke, k >= CKL);
         chk(init_done == (k >= done_k), (k >= done_k) ? "R8" : "R7", "done level",
             init_done, k >= done_k);
         if (c == C_NOP || c == C_INH) begin
            chk(c == (mem_cke ? C_NOP : C_INH), "R2", "idle code", c,
                mem_cke ? C_NOP : C_INH);
         end else if (q.size() == 0) begin
            chk(1'b0, "R8", "unexpected command", c, C_NOP);
         end else begin
            e = q.pop_front();
            chk(c == e.cmd, e.req, "command code", c, e.cmd);
            chk(k == e.k, e.req, "command cycle", k, e.k);
            chk(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
            chk(mem_ba == '0, e.req, "bank", mem_ba, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R8", "watchdog expired", k, done_k);
      summary();
   end

   initial begin
      // run 1: full sequence (R1..R8)
      repeat (3) @(negedge clk);
      #1 reset_state("R1");
      push_seq();
      @(negedge clk); #2 rst_n = 1'b1;
      wait_k(done_k + 20);
      chk(q.size() == 0, "R5", "expected commands left", q.size(), 0);
      chk(init_done == 1'b1, "R8", "done held", init_done, 1);

      // run 2: reset during the first refresh wait, then restart (R9)
      @(negedge clk); #2 rst_n = 1'b0;
      @(negedge clk); #1 reset_state("R1");
      push_seq();
      @(negedge clk); #2 rst_n = 1'b1;
      wait_k(S + RP + 4);
      #2 rst_n = 1'b0;
      #1 reset_state("R9");
      repeat (2) @(negedge clk);
      #1 reset_state("R9");
      push_seq();
      @(negedge clk); #2 rst_n = 1'b1;
      wait_k(done_k + 20);
      chk(q.size() == 0, "R9", "restart sequence complete", q.size(), 0);
      chk(init_done == 1'b1, "R9", "done after restart", init_done, 1);
      summary();
   end
endmodule